// File: doc/BRIEF.md
# Execution Timing and Result Bus Arbiter

This block sits between the reservation stations of an out-of-order core and its single shared result bus. When a station starts an operation, it hands over the operation type, the destination tag and the already computed result value. The block then counts down the fixed latency of that operation type. Once the countdown expires, the station holds its finished result and asks for the bus.

The result bus carries one result per cycle. When several finished operations compete for it, the block picks the winner by operation type and not by age. A younger load can therefore overtake an older add. Among operations of the same type, the station with the lower index wins. The winning station drives its tag and value onto the bus and is released in that same cycle. Each losing station keeps its result unchanged and asks again in the next cycle. The arithmetic itself and the operand wakeup logic live elsewhere.

Top module: `result_bus_sched`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, done_o and free_o are all zero and bus_valid_o is low.
- R2: Operation codes are 0 ADD, 1 SUB, 2 MUL, 3 DIV, 4 LOAD, 5 STORE. A start accepted in cycle c makes the station finished (done_o high) in cycle c+L. L is 1 for LOAD and STORE, 2 for ADD and SUB, 4 for MUL and 10 for DIV.
- R3: At most one bit of free_o is high in any cycle, and only for a station whose done_o is high. bus_valid_o is high exactly when at least one bit of done_o is high.
- R4: When several stations are finished, the bus goes to the highest-ranked type. The ranks, from highest to lowest, are LOAD, STORE, DIV, MUL, SUB, ADD. A store competes like any other type.
- R5: Among finished stations of the same type, the lowest station index wins.
- R6: A finished station that does not win keeps done_o high and keeps its tag and value unchanged in every later cycle until it wins.
- R7: In the cycle a station wins, bus_tag_o and bus_val_o carry that station's tag and value, and its free_o bit is high. A start to that station in the same cycle is accepted.
- R8: A start to a station that is busy and not freed in that cycle is ignored. The station later delivers its original tag and value, and no second result follows.
- R9: A start with operation code 6 or 7 is ignored, and the station stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | N_STN | Per-station start strobe |
| op_i | input | N_STN*3 | Per-station operation code |
| tag_i | input | N_STN*TAG_W | Per-station destination tag |
| val_i | input | N_STN*DATA_W | Per-station result value |
| bus_valid_o | output | 1 | Result bus carries a result this cycle |
| bus_tag_o | output | TAG_W | Tag on the result bus |
| bus_val_o | output | DATA_W | Value on the result bus |
| done_o | output | N_STN | Station has a finished result waiting |
| free_o | output | N_STN | Station wins the bus and is released this cycle |

## Verification
The directed patterns each isolate one effect:
- A load and an add that finish together separate type priority from age.
- Two multiplies that finish together separate the index tie-break from type priority.
- A divide shows that the long countdown does not expire early.
- A start sent to a busy station, and a start with an unused code, show that such starts are ignored.
- A restart in the cycle a station is freed shows that the station is reused back to back.

Random starts over all eight codes then build deep backlogs of mixed types. Every cycle the bench compares the bus, done_o and free_o against a reference model, which catches wrong retry or hold behaviour under contention.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_MUL   = 3'd2,
    OP_DIV   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5
  } op_e;

  localparam int RANK_W = 3;

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

  // bus priority, larger wins
  function automatic logic [RANK_W-1:0] op_rank(input logic [2:0] op);
    case (op)
      OP_LOAD:  return 3'd5;
      OP_STORE: return 3'd4;
      OP_DIV:   return 3'd3;
      OP_MUL:   return 3'd2;
      OP_SUB:   return 3'd1;
      default:  return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/stn_timer.sv
module stn_timer #(
  parameter int TAG_W      = 4,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 4,
  parameter int LAT_LDST   = 1,
  parameter int LAT_ADDSUB = 2,
  parameter int LAT_MUL    = 4,
  parameter int LAT_DIV    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              grant_i,
  output logic              done_o,
  output logic [2:0]        op_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] val_o
);
  import rbs_pkg::*;

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        op_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic [CNT_W-1:0]  load_cnt;
  logic              accept;

  always_comb begin
    case (op_i)
      OP_LOAD, OP_STORE: load_cnt = CNT_W'(LAT_LDST - 1);
      OP_ADD, OP_SUB:    load_cnt = CNT_W'(LAT_ADDSUB - 1);
      OP_MUL:            load_cnt = CNT_W'(LAT_MUL - 1);
      default:           load_cnt = CNT_W'(LAT_DIV - 1);
    endcase
  end

  // a station freed this cycle may restart at once
  assign accept = start_i && op_known(op_i) && (!busy_q || grant_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= '0;
      tag_q  <= '0;
      val_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= load_cnt;
      op_q   <= op_i;
      tag_q  <= tag_i;
      val_q  <= val_i;
    end else if (grant_i) begin
      busy_q <= 1'b0;
    end else if (busy_q && cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_q && (cnt_q == '0);
  assign op_o   = op_q;
  assign tag_o  = tag_q;
  assign val_o  = val_q;

  // R3
  grant_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> done_o);
  // R6
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !grant_i) |=> (done_o && $stable(tag_o) && $stable(val_o)));
  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !grant_i) |=> ($stable(tag_o) && $stable(op_o)));
endmodule

// File: rtl/bus_pick.sv
module bus_pick #(
  parameter int N_STN = 6,
  parameter int IDX_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_STN-1:0]       req_i,
  input  logic [N_STN-1:0][2:0]  rank_i,
  output logic [N_STN-1:0]       grant_o,
  output logic [IDX_W-1:0]       win_o,
  output logic                   any_o
);
  logic [2:0] best;

  always_comb begin
    best  = '0;
    win_o = '0;
    any_o = 1'b0;
    // strict compare keeps the lower index on a tie
    for (int i = 0; i < N_STN; i++) begin
      if (req_i[i] && (!any_o || rank_i[i] > best)) begin
        best  = rank_i[i];
        win_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
    grant_o = any_o ? (N_STN'(1) << win_o) : '0;
  end

  // R3
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  for (genvar j = 0; j < N_STN; j++) begin : g_chk
    // R4
    prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[j] |-> (any_o && rank_i[j] <= rank_i[win_o]));
    // R5
    tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[j] && rank_i[j] == rank_i[win_o]) |-> (IDX_W'(j) >= win_o));
  end
endmodule

// File: rtl/result_bus_sched.sv
module result_bus_sched #(
  parameter int N_STN      = 6,
  parameter int TAG_W      = 4,
  parameter int DATA_W     = 16,
  parameter int LAT_LDST   = 1,
  parameter int LAT_ADDSUB = 2,
  parameter int LAT_MUL    = 4,
  parameter int LAT_DIV    = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_STN-1:0]              start_i,
  input  logic [N_STN-1:0][2:0]         op_i,
  input  logic [N_STN-1:0][TAG_W-1:0]   tag_i,
  input  logic [N_STN-1:0][DATA_W-1:0]  val_i,
  output logic                          bus_valid_o,
  output logic [TAG_W-1:0]              bus_tag_o,
  output logic [DATA_W-1:0]             bus_val_o,
  output logic [N_STN-1:0]              done_o,
  output logic [N_STN-1:0]              free_o
);
  import rbs_pkg::*;

  localparam int IDX_W   = (N_STN > 1) ? $clog2(N_STN) : 1;
  localparam int LAT_M1  = (LAT_LDST > LAT_ADDSUB) ? LAT_LDST : LAT_ADDSUB;
  localparam int LAT_M2  = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
  localparam int CNT_W   = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;

  logic [N_STN-1:0][2:0]        op_q;
  logic [N_STN-1:0][2:0]        rank;
  logic [N_STN-1:0][TAG_W-1:0]  tag_q;
  logic [N_STN-1:0][DATA_W-1:0] val_q;
  logic [N_STN-1:0]             grant;
  logic [IDX_W-1:0]             win;
  logic                         any;

  for (genvar i = 0; i < N_STN; i++) begin : g_stn
    stn_timer #(
      .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .LAT_LDST(LAT_LDST), .LAT_ADDSUB(LAT_ADDSUB),
      .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
    ) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i[i]),
      .op_i    (op_i[i]),
      .tag_i   (tag_i[i]),
      .val_i   (val_i[i]),
      .grant_i (grant[i]),
      .done_o  (done_o[i]),
      .op_o    (op_q[i]),
      .tag_o   (tag_q[i]),
      .val_o   (val_q[i])
    );
    assign rank[i] = op_rank(op_q[i]);
  end

  bus_pick #(.N_STN(N_STN), .IDX_W(IDX_W)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (done_o),
    .rank_i  (rank),
    .grant_o (grant),
    .win_o   (win),
    .any_o   (any)
  );

  assign bus_valid_o = any;
  assign bus_tag_o   = any ? tag_q[win] : '0;
  assign bus_val_o   = any ? val_q[win] : '0;
  assign free_o      = grant;

  // R3
  bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o == (|done_o));
  // R7
  bus_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (free_o != '0));
endmodule

// File: tb/result_bus_sched_bench.sv
module result_bus_sched_bench;
  localparam int N = 6;
  localparam int TW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]          start;
  logic [N-1:0][2:0]     op;
  logic [N-1:0][TW-1:0]  tag;
  logic [N-1:0][DW-1:0]  val;
  logic                  bus_valid;
  logic [TW-1:0]         bus_tag;
  logic [DW-1:0]         bus_val;
  logic [N-1:0]          done;
  logic [N-1:0]          free;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  result_bus_sched u_result_bus_sched (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .tag_i(tag),
    .val_i(val), .bus_valid_o(bus_valid), .bus_tag_o(bus_tag),
    .bus_val_o(bus_val), .done_o(done), .free_o(free)
  );

  // reference model
  bit          m_busy [N];
  int          m_rem  [N];
  int          m_op   [N];
  int          m_tag  [N];
  int          m_val  [N];
  logic [N-1:0]         s_start;
  logic [N-1:0][2:0]    s_op;
  logic [N-1:0][TW-1:0] s_tag;
  logic [N-1:0][DW-1:0] s_val;

  function automatic int lat(input int o);
    if (o == 4 || o == 5) return 1;
    if (o == 0 || o == 1) return 2;
    if (o == 2) return 4;
    return 10;
  endfunction

  function automatic int rnk(input int o);
    case (o)
      4: return 5;
      5: return 4;
      3: return 3;
      2: return 2;
      1: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int winner();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (m_busy[i] && m_rem[i] == 0)
        if (w < 0 || rnk(m_op[i]) > rnk(m_op[w])) w = i;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int w = winner();
    logic [N-1:0] ed = '0;
    logic [N-1:0] ef = '0;
    for (int i = 0; i < N; i++) ed[i] = m_busy[i] && m_rem[i] == 0;
    if (w >= 0) ef[w] = 1'b1;
    chk(done == ed, "R2 done", done, ed);
    chk(free == ef, "R3 free", free, ef);
    chk(bus_valid == (w >= 0), "R3 valid", bus_valid, w >= 0);
    if (w >= 0) begin
      chk(bus_tag == TW'(m_tag[w]), "R7 tag", bus_tag, m_tag[w]);
      chk(bus_val == DW'(m_val[w]), "R7 val", bus_val, m_val[w]);
    end
  endtask

  task automatic launch(input int i, input int o, input int t, input int v);
    s_start[i] = 1'b1;
    s_op[i] = 3'(o);
    s_tag[i] = TW'(t);
    s_val[i] = DW'(v);
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step();
    int w = winner();
    start = s_start; op = s_op; tag = s_tag; val = s_val;
    for (int i = 0; i < N; i++) begin
      bit acc = s_start[i] && s_op[i] < 6 && (!m_busy[i] || i == w);
      if (acc) begin
        m_busy[i] = 1; m_rem[i] = lat(s_op[i]) - 1;
        m_op[i] = s_op[i]; m_tag[i] = s_tag[i]; m_val[i] = s_val[i];
      end else if (i == w) m_busy[i] = 0;
      else if (m_busy[i] && m_rem[i] > 0) m_rem[i]--;
    end
    s_start = '0;
    @(posedge clk);
    @(negedge clk);
    start = '0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    start = '0; op = '0; tag = '0; val = '0;
    s_start = '0; s_op = '0; s_tag = '0; s_val = '0;
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_rem[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 in reset
    chk(done == '0 && free == '0 && !bus_valid, "R1", {done, free, bus_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == '0 && !bus_valid, "R1", {done, bus_valid}, 0);

    // R4: older ADD and younger LOAD finish together
    launch(0, 0, 1, 16'h0a0a); step();
    launch(1, 4, 2, 16'h0b0b); step();
    chk(bus_valid && bus_tag == 2, "R4 load first", bus_tag, 2);
    chk(done == 6'b000011, "R6 add waits", done, 6'b000011);
    step();
    chk(bus_valid && bus_tag == 1 && bus_val == 16'h0a0a, "R6 add retries", bus_tag, 1);
    idle(2);

    // R4: STORE beats DIV and MUL
    launch(2, 3, 3, 3); step();
    idle(5);
    launch(4, 2, 4, 4); step();
    idle(2);
    launch(5, 5, 5, 5); step();
    chk(bus_tag == 5 && free == 6'b100000, "R4 store", bus_tag, 5);
    step();
    chk(bus_tag == 3, "R4 div over mul", bus_tag, 3);
    step();
    chk(bus_tag == 4, "R4 mul last", bus_tag, 4);
    idle(2);

    // R2: DIV latency 10
    launch(3, 3, 7, 77); step();
    idle(8);
    chk(done[3] == 1'b0, "R2 div early", done[3], 0);
    step();
    chk(done[3] && bus_tag == 7, "R2 div on time", bus_tag, 7);
    idle(1);

    // R5: two MULs finish together
    launch(3, 2, 8, 8); launch(1, 2, 9, 9); step();
    idle(3);
    chk(bus_tag == 9 && free == 6'b000010, "R5 low index", bus_tag, 9);
    step();
    chk(bus_tag == 8, "R5 second", bus_tag, 8);
    idle(1);

    // R8: start to busy station ignored
    launch(0, 1, 10, 100); step();
    launch(0, 4, 11, 111); step();
    chk(bus_tag == 10 && bus_val == 100, "R8 original kept", bus_tag, 10);
    step();
    chk(!bus_valid && done == '0, "R8 no extra", bus_valid, 0);

    // R9: unused codes
    launch(2, 6, 12, 1); launch(4, 7, 13, 1); step();
    idle(11);
    chk(done == '0 && !bus_valid, "R9 ignored", done, 0);

    // R7: restart in the freed cycle
    launch(0, 4, 14, 140); step();
    chk(bus_tag == 14 && free[0], "R7 first", bus_tag, 14);
    launch(0, 4, 15, 150); step();
    chk(bus_tag == 15 && bus_val == 150, "R7 restart", bus_tag, 15);
    idle(2);

    // random contention, R2 R3 R4 R5 R6 R7 checked every cycle
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++)
        if ($urandom_range(3) == 0)
          launch(i, $urandom_range(7), $urandom_range(15), $urandom_range(16'hffff));
      step();
    end
    idle(30);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule